// File: doc/BRIEF.md
# Interrupt Source Merger with Enable Masks

This block collects sixteen level-type interrupt requests from peripherals and folds them onto eight level request lines that feed a priority interrupt controller. Some requests pass through an enable bit held in one of two mask registers. Others always reach their line. The routing is fixed, and several requests share each line. The merged lines are registered, so they change one clock after a request or a mask changes.

Software loads the two mask registers through writes on an 8-bit I/O bus. It reads the raw state of the requests, before any masking, from three status addresses. All other read addresses return 0xFF. While keyboard enable is clear, the keyboard request does not reach its line. Instead it is sent out on a separate forwarding output for the sub-system.

Top module: `intm_top`

## Requirements
- R1: After reset both mask registers hold 0, all eight request lines are low and the forwarding output is low. With masks at 0, masked requests never raise their lines.
- R2: A write strobe at address 0xFD02 loads the main mask and at 0xFD2C loads the extended mask. Writes to any other address, and data with the strobe low, leave both masks unchanged.
- R3: Line 0 is timer (src_i[10]) AND main mask bit 4. Line 6 is low-density floppy (src_i[6]) AND main bit 5. Line 7 is printer (src_i[9]) AND main bit 0.
- R4: Line 4 is the OR of serial transmit (src_i[0]) AND main bit 1, serial receive (src_i[1]) AND main bit 2, and serial sync (src_i[2]) AND main bit 3.
- R5: Line 3 is the OR of sub-system attention (src_i[12]), fast expansion (src_i[14]) and fast user (src_i[15]). Line 5 is expansion (src_i[4]) OR user (src_i[11]). None of these is masked.
- R6: Line 1 is keyboard (src_i[3]) AND main bit 7, ORed with break (src_i[13]).
- R7: Line 2 is high-density floppy (src_i[7]) AND extended mask bit 3, ORed with hard disk (src_i[8]).
- R8: The forwarding output is keyboard (src_i[3]) AND NOT main bit 7.
- R9: The DMA-complete request (src_i[5]) drives no request line.
- R10: A read at 0xFD03 returns the unmasked requests: bit0 timer, bit1 printer, bit2 0, bit3 low-density floppy, bit4 DMA, bit5 expansion, bit6 keyboard, bit7 the OR of the three serial requests.
- R11: A read at 0xFD04 returns attention in bit0, break in bit1 and fast expansion in bit7, with the other bits 0. A read at 0xFD2C returns hard disk in bit2 and high-density floppy in bit6, with the other bits 0.
- R12: A read at any other address returns 0xFF.
- R13: Lines and the forwarding output are registered. A request change shows one clock later. A mask write is used from the following cycle, so in the cycle of the write the old mask still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for io_addr (combinational) |
| src_i | input | 16 | Peripheral request levels, positions as in the requirements |
| irq_o | output | 8 | Merged request lines to the priority controller |
| kbd_fwd_o | output | 1 | Keyboard request forwarded to the sub-system |

## Verification
The bench drives each request alone with every enable set, which exposes a request routed to the wrong line or a DMA request that leaks onto a line. It then walks the serial enables one bit at a time, which catches enables that are swapped or shared. Writes to a neighbouring address and data with the strobe low must leave the lines unchanged, so a loose address decode shows up. A mask write made in the same cycle as a request change must still apply the old mask for that cycle, so a design that applied the mask in the write cycle, or one cycle too late, produces a one-cycle mismatch. The status reads use asymmetric patterns, which catch swapped bits or a missing 0xFF default.

// File: rtl/intm_pkg.sv
package intm_pkg;
  localparam int SRC_N  = 16;
  localparam int LINE_N = 8;

  // request positions on src_i
  localparam int S_SER_TX  = 0;
  localparam int S_SER_RX  = 1;
  localparam int S_SER_SYN = 2;
  localparam int S_KBD     = 3;
  localparam int S_EXP     = 4;
  localparam int S_DMA     = 5;
  localparam int S_LOFD    = 6;
  localparam int S_HIFD    = 7;
  localparam int S_HDD     = 8;
  localparam int S_PRN     = 9;
  localparam int S_TMR     = 10;
  localparam int S_USR     = 11;
  localparam int S_F_SUB   = 12;
  localparam int S_F_BRK   = 13;
  localparam int S_F_EXP   = 14;
  localparam int S_F_USR   = 15;

  // decoded I/O addresses
  localparam logic [15:0] A_MASK_MAIN = 16'hFD02;
  localparam logic [15:0] A_STAT_RAW  = 16'hFD03;
  localparam logic [15:0] A_STAT_FAST = 16'hFD04;
  localparam logic [15:0] A_MASK_EXT  = 16'hFD2C;
endpackage

// File: rtl/intm_masks.sv
module intm_masks
  import intm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_main,
  output logic [DATA_W-1:0] en_ext
);
  logic ld_main, ld_ext;
  logic [DATA_W-1:0] main_q, ext_q;

  always_comb begin
    ld_main = wr && (addr == ADDR_W'(A_MASK_MAIN));
    ld_ext  = wr && (addr == ADDR_W'(A_MASK_EXT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= '0;
      ext_q  <= '0;
    end else begin
      if (ld_main) main_q <= wdata;
      if (ld_ext)  ext_q  <= wdata;
    end
  end

  assign en_main = main_q;
  assign en_ext  = ext_q;

  a_r2_main_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_W'(A_MASK_MAIN)) |=> (main_q == $past(wdata)));
  a_r2_main_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == ADDR_W'(A_MASK_MAIN)) |=> $stable(main_q));
  a_r2_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == ADDR_W'(A_MASK_EXT)) |=> $stable(ext_q));
endmodule

// File: rtl/intm_merge.sv
module intm_merge
  import intm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  src,
  input  logic [DATA_W-1:0] en_main,
  input  logic [DATA_W-1:0] en_ext,
  output logic [LINE_N-1:0] irq,
  output logic              kbd_fwd
);
  logic [LINE_N-1:0] req_d, req_q;
  logic fwd_d, fwd_q;
  logic unused_bits;

  assign unused_bits = ^{en_main[6], en_ext[DATA_W-1:4], en_ext[2:0], src[S_DMA]};

  always_comb begin
    req_d[0] = src[S_TMR]  & en_main[4];
    req_d[1] = (src[S_KBD] & en_main[7]) | src[S_F_BRK];
    req_d[2] = (src[S_HIFD] & en_ext[3]) | src[S_HDD];
    req_d[3] = src[S_F_SUB] | src[S_F_EXP] | src[S_F_USR];
    req_d[4] = (src[S_SER_TX]  & en_main[1])
             | (src[S_SER_RX]  & en_main[2])
             | (src[S_SER_SYN] & en_main[3]);
    req_d[5] = src[S_EXP] | src[S_USR];
    req_d[6] = src[S_LOFD] & en_main[5];
    req_d[7] = src[S_PRN]  & en_main[0];
    fwd_d    = src[S_KBD] & ~en_main[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      fwd_q <= 1'b0;
    end else begin
      req_q <= req_d;
      fwd_q <= fwd_d;
    end
  end

  assign irq     = req_q;
  assign kbd_fwd = fwd_q;

  a_r5_attention_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    src[S_F_SUB] |=> irq[3]);
  a_r3_timer_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !en_main[4] |=> !irq[0]);
  a_r8_fwd_off_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    en_main[7] |=> !kbd_fwd);
  a_r5_user_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    src[S_USR] |=> irq[5]);
endmodule

// File: rtl/intm_status.sv
module intm_status
  import intm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SRC_N-1:0]  src,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] raw_v, fast_v, ext_v;
  logic unused_src;

  assign unused_src = ^{src[S_USR], src[S_F_USR]};

  always_comb begin
    raw_v = '0;
    raw_v[0] = src[S_TMR];
    raw_v[1] = src[S_PRN];
    raw_v[3] = src[S_LOFD];
    raw_v[4] = src[S_DMA];
    raw_v[5] = src[S_EXP];
    raw_v[6] = src[S_KBD];
    raw_v[7] = src[S_SER_TX] | src[S_SER_RX] | src[S_SER_SYN];

    fast_v = '0;
    fast_v[0] = src[S_F_SUB];
    fast_v[1] = src[S_F_BRK];
    fast_v[7] = src[S_F_EXP];

    ext_v = '0;
    ext_v[2] = src[S_HDD];
    ext_v[6] = src[S_HIFD];

    if (addr == ADDR_W'(A_STAT_RAW))       rdata = raw_v;
    else if (addr == ADDR_W'(A_STAT_FAST)) rdata = fast_v;
    else if (addr == ADDR_W'(A_MASK_EXT))  rdata = ext_v;
    else                                   rdata = '1;
  end
endmodule

// File: rtl/intm_top.sv
module intm_top
  import intm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic [SRC_N-1:0]  src_i,
  output logic [LINE_N-1:0] irq_o,
  output logic              kbd_fwd_o
);
  logic [1:0] rsync_q;
  logic rst_sn;
  logic [DATA_W-1:0] en_main, en_ext;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  intm_masks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_masks (
    .clk(clk), .rst_n(rst_sn), .wr(io_wr), .addr(io_addr),
    .wdata(io_wdata), .en_main(en_main), .en_ext(en_ext)
  );

  intm_merge #(.DATA_W(DATA_W)) u_merge (
    .clk(clk), .rst_n(rst_sn), .src(src_i), .en_main(en_main),
    .en_ext(en_ext), .irq(irq_o), .kbd_fwd(kbd_fwd_o)
  );

  intm_status #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_status (
    .addr(io_addr), .src(src_i), .rdata(io_rdata)
  );

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sn |=> (irq_o == '0 && !kbd_fwd_o));
endmodule

// File: tb/intm_top_test.sv
`timescale 1ns/1ps
module intm_top_test;
  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] io_addr;
  logic io_wr;
  logic [7:0] io_wdata, io_rdata;
  logic [15:0] src;
  logic [7:0] irq;
  logic kbd_fwd;

  int n_chk = 0;
  int n_err = 0;

  typedef struct { logic [8:0] v; string tag; } exp_t;
  exp_t sbq[$];

  logic [7:0] m_main = 8'h00;
  logic [7:0] m_ext  = 8'h00;

  always #4 clk = ~clk;

  intm_top uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .src_i(src),
    .irq_o(irq), .kbd_fwd_o(kbd_fwd)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected {fwd, lines} from the requirements
  function automatic logic [8:0] model(logic [15:0] s, logic [7:0] e, logic [7:0] x);
    logic [7:0] l;
    l[0] = s[10] & e[4];
    l[1] = (s[3] & e[7]) | s[13];
    l[2] = (s[7] & x[3]) | s[8];
    l[3] = s[12] | s[14] | s[15];
    l[4] = (s[0] & e[1]) | (s[1] & e[2]) | (s[2] & e[3]);
    l[5] = s[4] | s[11];
    l[6] = s[6] & e[5];
    l[7] = s[9] & e[0];
    return {s[3] & ~e[7], l};
  endfunction

  function automatic logic [7:0] rd_model(logic [15:0] a, logic [15:0] s);
    case (a)
      16'hFD03: return {s[0] | s[1] | s[2], s[3], s[4], s[5], s[6], 1'b0, s[9], s[10]};
      16'hFD04: return {s[14], 5'b0, s[13], s[12]};
      16'hFD2C: return {1'b0, s[7], 3'b0, s[8], 2'b0};
      default:  return 8'hFF;
    endcase
  endfunction

  function automatic string tag_of(int i);
    case (i)
      0, 1, 2: return "R4";
      3:       return "R6";
      4, 11, 12, 14, 15: return "R5";
      5:       return "R9";
      7, 8:    return "R7";
      13:      return "R6";
      default: return "R3";
    endcase
  endfunction

  // driver: one cycle of stimulus, expected result pushed for the next edge
  task automatic cyc(logic [15:0] s, logic w, logic [15:0] a, logic [7:0] d, string tag);
    exp_t e;
    @(negedge clk);
    src = s; io_wr = w; io_addr = a; io_wdata = d;
    e.v = model(s, m_main, m_ext);
    e.tag = tag;
    sbq.push_back(e);
    if (w) begin
      if (a == 16'hFD02) m_main = d;
      else if (a == 16'hFD2C) m_ext = d;
    end
  endtask

  task automatic rd(logic [15:0] s, logic [15:0] a, string tag);
    @(negedge clk);
    src = s; io_wr = 1'b0; io_addr = a;
    #1 chk(tag, {8'h00, io_rdata}, {8'h00, rd_model(a, s)});
  endtask

  // monitor: compare after each rising edge
  initial forever begin
    exp_t e;
    @(posedge clk);
    #2;
    if (sbq.size() > 0) begin
      e = sbq.pop_front();
      chk(e.tag, {7'h00, kbd_fwd, irq}, {7'h00, e.v});
    end
  end

  initial begin
    #(8 * 100000);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src = '0; io_wr = 1'b0; io_addr = '0; io_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {8'h00, irq}, 16'h0000);
    chk("R1", {15'h0, kbd_fwd}, 16'h0000);

    // masks still zero after reset
    cyc(16'hFFFF, 1'b0, 16'h0000, 8'h00, "R1");
    cyc(16'h0008, 1'b0, 16'h0000, 8'h00, "R8");

    cyc(16'h0000, 1'b1, 16'hFD02, 8'hFF, "R2");
    cyc(16'h0008, 1'b0, 16'h0000, 8'h00, "R8");
    cyc(16'h0000, 1'b1, 16'hFD2C, 8'h08, "R2");

    for (int i = 0; i < 16; i++)
      cyc(16'(1 << i), 1'b0, 16'h0000, 8'h00, tag_of(i));

    // one serial enable at a time
    cyc(16'h0000, 1'b1, 16'hFD02, 8'h02, "R4");
    cyc(16'h0007, 1'b0, 16'h0000, 8'h00, "R4");
    cyc(16'h0002, 1'b1, 16'hFD02, 8'h04, "R4");
    cyc(16'h0001, 1'b0, 16'h0000, 8'h00, "R4");
    cyc(16'h0002, 1'b0, 16'h0000, 8'h00, "R4");
    cyc(16'h0000, 1'b1, 16'hFD02, 8'h08, "R4");
    cyc(16'h0003, 1'b0, 16'h0000, 8'h00, "R4");
    cyc(16'h0004, 1'b0, 16'h0000, 8'h00, "R4");

    // writes that must not land
    cyc(16'h0000, 1'b1, 16'hFD02, 8'hFF, "R2");
    cyc(16'h0000, 1'b1, 16'hFD03, 8'h00, "R2");
    cyc(16'h0000, 1'b1, 16'hFD12, 8'h00, "R2");
    cyc(16'h0000, 1'b0, 16'hFD02, 8'h00, "R2");
    cyc(16'h0000, 1'b0, 16'hFD2C, 8'h00, "R2");
    cyc(16'hFFFF, 1'b0, 16'h0000, 8'h00, "R2");
    cyc(16'h0640, 1'b0, 16'h0000, 8'h00, "R3");

    // extended enable cleared
    cyc(16'h0000, 1'b1, 16'hFD2C, 8'hF7, "R7");
    cyc(16'h0080, 1'b0, 16'h0000, 8'h00, "R7");
    cyc(16'h0180, 1'b0, 16'h0000, 8'h00, "R7");

    // mask write and request change in the same cycle
    cyc(16'h0400, 1'b1, 16'hFD02, 8'h00, "R13");
    cyc(16'h0400, 1'b0, 16'h0000, 8'h00, "R13");
    cyc(16'h0208, 1'b1, 16'hFD02, 8'h81, "R13");
    cyc(16'h0208, 1'b0, 16'h0000, 8'h00, "R13");
    cyc(16'h0000, 1'b0, 16'h0000, 8'h00, "R13");

    // status reads
    foreach (sbq[k]) ; // no-op keeps queue untouched
    begin
      logic [15:0] pats [5] = '{16'h0000, 16'hFFFF, 16'h5A5A, 16'hA5A5, 16'h1234};
      for (int p = 0; p < 5; p++) begin
        rd(pats[p], 16'hFD03, "R10");
        rd(pats[p], 16'hFD04, "R11");
        rd(pats[p], 16'hFD2C, "R11");
        rd(pats[p], 16'hFD02, "R12");
        rd(pats[p], 16'hFD05, "R12");
        rd(pats[p], 16'h0000, "R12");
      end
    end

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule